// File: doc/BRIEF.md
# SMBus Block Configuration Slave

This block is a two-wire serial slave that answers at one fixed 7-bit address. It supports exactly two transfers: a block write and a block read. A fast system clock samples SCL and SDA. The block drives SDA only by pulling it low through an output-enable, so the pad works as open-drain. Six configuration bytes are held in a small register file, and their contents go straight out to the clock gating logic as one flat vector.

A write starts with the address byte 0xD4. Two bytes then follow that the slave acknowledges and throws away: a command byte and a count byte. After them come data bytes, which always land in order starting at register 0. The host may end the transfer with a stop after any whole byte.

A read starts with the address byte 0xD5. The slave answers with a count byte of 6 and then the six registers. The host acknowledges each byte, and a not-acknowledge ends the stream. A start or stop seen at any moment abandons the byte in progress.

Top module: `cfg_block_slave`

## Requirements
- R1: After reset, register 0 reads 0x00 and registers 1 to 5 read 0xFF. Register k occupies cfg_o[8k+7:8k].
- R2: The slave acknowledges only the address bytes 0xD4 (write) and 0xD5 (read). For any other address byte it leaves SDA released through the acknowledge slot and waits for the next start.
- R3: In a write, the first two bytes after the address are acknowledged and have no effect on any register. Each following byte is acknowledged and stored in registers 0, 1, 2 and so on, in order.
- R4: A stop after n complete data bytes (0 to 6) updates exactly registers 0 to n-1. A data byte cut short by a stop leaves its register unchanged.
- R5: A read returns the byte 6, then registers 0 to 5, each sent MSB first. Any further byte the host clocks out while still acknowledging is 0xFF.
- R6: When the host does not acknowledge a read byte, the slave releases SDA and stays released until the next start.
- R7: A repeated start in the middle of a byte abandons that byte and returns the slave to address matching. A stop abandons the byte and returns the slave to idle.
- R8: The slave changes its SDA drive only while SCL is low. A start condition releases SDA on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 48 | Six configuration registers; register k in bits 8k+7:8k |

## Verification
The assertions assume a well-behaved host:
- It changes SDA while SCL is high only to form a start or a stop.
- It never forms a stop while the slave is pulling SDA low.
- Each SCL phase lasts many system clocks longer than the synchronizer and edge-detect latency.

The bench meets these assumptions. It drives the bus on falling system-clock edges and holds each SCL half period for 20 clocks. It places stops and repeated starts only where SDA is released, or where the host itself is driving it.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_WACK,
        ST_TX,
        ST_HACK
    } slv_state_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= RST_VAL;
                end else if (i == 0) begin
                    stage_q[i] <= din;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cfgslv_cond.sv
module cfgslv_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_s;

    prev_s prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
        scl_rise   = scl_s & ~prev_q.scl;
        scl_fall   = ~scl_s & prev_q.scl;
        ev_start   = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
        ev_stop    = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/cfgslv_regs.sv
module cfgslv_regs #(
    parameter int                        NUM_BYTES = 6,
    parameter int                        BI_W      = 3,
    parameter logic [NUM_BYTES*8-1:0]    DEFAULTS  = 48'hFFFF_FFFF_FF00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [BI_W-1:0]        wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [BI_W-1:0]        rd_idx,
    output logic [7:0]             rd_data,
    output logic [NUM_BYTES*8-1:0] cfg_o
);

    logic [NUM_BYTES*8-1:0] bytes_d, bytes_q;

    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
            always_comb begin
                if (wr_en && (wr_idx == BI_W'(i))) begin
                    bytes_d[8*i +: 8] = wr_data;
                end else begin
                    bytes_d[8*i +: 8] = bytes_q[8*i +: 8];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bytes_q[8*i +: 8] <= DEFAULTS[8*i +: 8];
                end else begin
                    bytes_q[8*i +: 8] <= bytes_d[8*i +: 8];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (rd_idx == BI_W'(k)) begin
                rd_data = bytes_q[8*k +: 8];
            end
        end
    end

    assign cfg_o = bytes_q;

endmodule

// File: rtl/cfgslv_fsm.sv
module cfgslv_fsm
    import cfgslv_pkg::*;
#(
    parameter int         NUM_BYTES = 6,
    parameter int         IDX_W     = 4,
    parameter int         BI_W      = 3,
    parameter logic [6:0] ADDR7     = 7'h6A
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            ev_start,
    input  logic            ev_stop,
    input  logic [7:0]      rd_data,
    output logic [BI_W-1:0] rd_idx,
    output logic            wr_en,
    output logic [BI_W-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic            sda_oe,
    output logic            idle_o
);

    localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(NUM_BYTES + 2);
    localparam logic [IDX_W-1:0] DATA_LO   = IDX_W'(2);
    localparam logic [IDX_W-1:0] DATA_END  = IDX_W'(NUM_BYTES + 2);
    localparam logic [IDX_W-1:0] READ_LAST = IDX_W'(NUM_BYTES);

    typedef struct packed {
        slv_state_e       st;
        logic [7:0]       sh;
        logic [3:0]       bc;
        logic [IDX_W-1:0] idx;
        logic             rw;
        logic             nack;
        logic             oe;
    } fsm_s;

    fsm_s       cur_q, nxt_d;
    logic [7:0] tx_byte;

    always_comb begin
        if (cur_q.idx == '0) begin
            tx_byte = 8'(NUM_BYTES);
        end else if (cur_q.idx <= READ_LAST) begin
            tx_byte = rd_data;
        end else begin
            tx_byte = FILL_BYTE;
        end
    end

    always_comb begin
        nxt_d   = cur_q;
        wr_en   = 1'b0;
        wr_idx  = BI_W'(cur_q.idx - DATA_LO);
        wr_data = cur_q.sh;
        rd_idx  = BI_W'(cur_q.idx - IDX_W'(1));

        if (ev_start) begin
            nxt_d.st   = ST_ADDR;
            nxt_d.bc   = '0;
            nxt_d.sh   = '0;
            nxt_d.idx  = '0;
            nxt_d.nack = 1'b0;
            nxt_d.oe   = 1'b0;
        end else if (ev_stop) begin
            nxt_d.st = ST_IDLE;
            nxt_d.oe = 1'b0;
        end else begin
            case (cur_q.st)
                ST_IDLE: begin
                    nxt_d.oe = 1'b0;
                end
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        nxt_d.sh = {cur_q.sh[6:0], sda_s};
                        nxt_d.bc = cur_q.bc + 4'd1;
                    end else if (scl_fall && cur_q.bc == 4'd8) begin
                        nxt_d.bc = '0;
                        if (cur_q.st == ST_ADDR) begin
                            if (cur_q.sh[7:1] == ADDR7) begin
                                nxt_d.oe = 1'b1;
                                nxt_d.rw = cur_q.sh[0];
                                nxt_d.st = ST_AACK;
                            end else begin
                                nxt_d.st = ST_IDLE;
                            end
                        end else begin
                            nxt_d.oe = 1'b1;
                            nxt_d.st = ST_WACK;
                            if (cur_q.idx >= DATA_LO && cur_q.idx < DATA_END) begin
                                wr_en = 1'b1;
                            end
                            if (cur_q.idx != IDX_MAX) begin
                                nxt_d.idx = cur_q.idx + IDX_W'(1);
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        nxt_d.bc = '0;
                        if (cur_q.rw) begin
                            nxt_d.sh  = tx_byte;
                            nxt_d.oe  = ~tx_byte[7];
                            nxt_d.idx = cur_q.idx + IDX_W'(1);
                            nxt_d.st  = ST_TX;
                        end else begin
                            nxt_d.oe = 1'b0;
                            nxt_d.st = ST_RX;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        nxt_d.oe = 1'b0;
                        nxt_d.st = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        nxt_d.bc = cur_q.bc + 4'd1;
                    end else if (scl_fall) begin
                        if (cur_q.bc == 4'd8) begin
                            nxt_d.oe = 1'b0;
                            nxt_d.bc = '0;
                            nxt_d.st = ST_HACK;
                        end else begin
                            nxt_d.sh = {cur_q.sh[6:0], 1'b0};
                            nxt_d.oe = ~cur_q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        nxt_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (cur_q.nack) begin
                            nxt_d.oe = 1'b0;
                            nxt_d.st = ST_IDLE;
                        end else begin
                            nxt_d.sh = tx_byte;
                            nxt_d.oe = ~tx_byte[7];
                            nxt_d.bc = '0;
                            nxt_d.st = ST_TX;
                            if (cur_q.idx != IDX_MAX) begin
                                nxt_d.idx = cur_q.idx + IDX_W'(1);
                            end
                        end
                    end
                end
                default: begin
                    nxt_d.st = ST_IDLE;
                    nxt_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, sh: '0, bc: '0, idx: '0, rw: 1'b0, nack: 1'b0, oe: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sda_oe = cur_q.oe;
    assign idle_o = (cur_q.st == ST_IDLE);

endmodule

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
    parameter int                     NUM_BYTES   = 6,
    parameter int                     SYNC_STAGES = 2,
    parameter logic [6:0]             ADDR7       = 7'h6A,
    parameter logic [NUM_BYTES*8-1:0] DEFAULTS    = 48'hFFFF_FFFF_FF00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NUM_BYTES*8-1:0] cfg_o
);

    localparam int IDX_W = $clog2(NUM_BYTES + 3);
    localparam int BI_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    logic [1:0]      bus_s;
    logic            scl_s, sda_s;
    logic            scl_rise, scl_fall, ev_start, ev_stop;
    logic            wr_en, fsm_idle;
    logic [BI_W-1:0] wr_idx, rd_idx;
    logic [7:0]      wr_data, rd_data;

    cfgslv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    cfgslv_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .ev_start(ev_start),
        .ev_stop (ev_stop)
    );

    cfgslv_fsm #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .BI_W(BI_W), .ADDR7(ADDR7)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sda_oe  (sda_oe),
        .idle_o  (fsm_idle)
    );

    cfgslv_regs #(.NUM_BYTES(NUM_BYTES), .BI_W(BI_W), .DEFAULTS(DEFAULTS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .cfg_o  (cfg_o)
    );

endmodule

// File: rtl/cfg_block_slave_chk.sv
module cfg_block_slave_chk #(
    parameter int NUM_BYTES = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sda_oe,
    input logic                   scl_s,
    input logic                   ev_start,
    input logic                   ev_stop,
    input logic                   fsm_idle,
    input logic                   wr_en,
    input logic [NUM_BYTES*8-1:0] cfg_o
);

    // R8
    oe_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe);

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> fsm_idle);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !sda_oe);

    // R4
    cfg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(wr_en));

endmodule

bind cfg_block_slave cfg_block_slave_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .scl_s   (scl_s),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .fsm_idle(fsm_idle),
    .wr_en   (wr_en),
    .cfg_o   (cfg_o)
);

// File: tb/cfg_block_slave_tb.sv
`timescale 1ns/1ps
module cfg_block_slave_tb;

    localparam int HP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        host_low = 1'b0;
    logic        sda_oe;
    logic [47:0] cfg_o;
    wire         sda_bus = !(host_low || sda_oe);

    int total = 0;
    int bad = 0;
    int viol = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    logic [7:0] exp_b [6];

    always #4 clk = ~clk;

    cfg_block_slave u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl),
        .sda_i (sda_bus),
        .sda_oe(sda_oe),
        .cfg_o (cfg_o)
    );

    // R8 monitor: drive changes seen while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && (sda_oe != oe_prev)) viol++;
        scl_prev <= scl;
        oe_prev  <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [47:0] exp_cfg();
        logic [47:0] v;
        for (int k = 0; k < 6; k++) v[8*k +: 8] = exp_b[k];
        return v;
    endfunction

    task automatic hw();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; hw();
        scl = 1'b1; hw();
        host_low = 1'b1; hw();
        scl = 1'b0; hw();
    endtask

    task automatic bus_stop();
        scl = 1'b0; host_low = 1'b1; hw();
        scl = 1'b1; hw();
        host_low = 1'b0; hw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            host_low = ~b[i]; hw();
            scl = 1'b1; hw();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        host_low = 1'b0; hw();
        scl = 1'b1; hw();
        ack = (sda_bus == 1'b0);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        host_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hw();
            scl = 1'b1; hw();
            b = {b[6:0], sda_bus};
            scl = 1'b0;
        end
        host_low = give_ack; hw();
        scl = 1'b1; hw();
        scl = 1'b0;
    endtask

    task automatic do_write(input int n, input logic [7:0] cmd, input logic [7:0] cnt, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'hD4, a); all_ack &= a;
        send_byte(cmd, a);   all_ack &= a;
        send_byte(cnt, a);   all_ack &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(exp_b[k], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic read_all(input string tag);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD5, a);
        chk(a, {tag, " R2 read address ack"}, 64'(a), 64'd1);
        recv_byte(1'b1, b);
        chk(b == 8'd6, {tag, " R5 count byte"}, 64'(b), 64'd6);
        for (int k = 0; k < 6; k++) begin
            recv_byte(1'b1, b);
            chk(b == exp_b[k], {tag, " R5 data byte"}, 64'(b), 64'(exp_b[k]));
        end
        recv_byte(1'b0, b);
        chk(b == 8'hFF, {tag, " R5 fill after last"}, 64'(b), 64'hFF);
        bus_stop();
    endtask

    initial begin
        bit a;
        bit all_ack;
        logic [7:0] b;
        exp_b[0] = 8'h00;
        for (int k = 1; k < 6; k++) exp_b[k] = 8'hFF;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(cfg_o == 48'hFFFF_FFFF_FF00, "R1 reset defaults", 64'(cfg_o), 64'hFFFF_FFFF_FF00);
        chk(sda_bus == 1'b1, "R1 bus released", 64'(sda_bus), 64'd1);
        read_all("R1");

        // R2 address sweep
        for (int s = 0; s < 18; s++) begin
            logic [7:0] ad;
            ad = (s == 16) ? 8'hD4 : (s == 17) ? 8'hD5 : 8'(s * 17);
            bus_start();
            send_byte(ad, a);
            chk(a == ((ad == 8'hD4) || (ad == 8'hD5)), "R2 address match", 64'(a), 64'(ad));
            if (ad == 8'hD5) recv_byte(1'b0, b);
            bus_stop();
        end

        // R3 full writes with varied command and count, then read back
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 6; k++) exp_b[k] = 8'((p * 37 + k * 29 + 5) & 8'hFF);
            do_write(6, 8'(p * 11), 8'(8'h33 + p), all_ack);
            chk(all_ack, "R3 all bytes acked", 64'(all_ack), 64'd1);
            repeat (10) @(negedge clk);
            chk(cfg_o == exp_cfg(), "R3 stored in order", 64'(cfg_o), 64'(exp_cfg()));
            read_all("R3");
        end

        // R4 partial writes of n complete bytes
        for (int n = 0; n <= 6; n++) begin
            for (int k = 0; k < n; k++) exp_b[k] = 8'(~(n * 19 + k));
            do_write(n, 8'hA5, 8'h5A, all_ack);
            repeat (10) @(negedge clk);
            chk(cfg_o == exp_cfg(), "R4 partial write", 64'(cfg_o), 64'(exp_cfg()));
        end

        // R4 / R7 byte cut short by a stop
        exp_b[0] = 8'h3C;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        send_byte(exp_b[0], a);
        send_bits(8'h00, 4);
        bus_stop();
        repeat (10) @(negedge clk);
        chk(cfg_o == exp_cfg(), "R4 incomplete byte ignored", 64'(cfg_o), 64'(exp_cfg()));

        // R7 repeated start mid-byte then read
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_bits(8'h00, 5);
        bus_start();
        send_byte(8'hD5, a);
        chk(a, "R7 address after repeated start", 64'(a), 64'd1);
        recv_byte(1'b1, b);
        chk(b == 8'd6, "R7 count after repeated start", 64'(b), 64'd6);
        recv_byte(1'b0, b);
        chk(b == exp_b[0], "R7 byte0 untouched", 64'(b), 64'(exp_b[0]));
        bus_stop();
        repeat (10) @(negedge clk);
        chk(cfg_o == exp_cfg(), "R7 registers untouched", 64'(cfg_o), 64'(exp_cfg()));

        // R6 nack after count byte: next clocked byte must be all released
        bus_start();
        send_byte(8'hD5, a);
        recv_byte(1'b0, b);
        chk(b == 8'd6, "R6 count before nack", 64'(b), 64'd6);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R6 released after nack", 64'(b), 64'hFF);
        chk(sda_bus == 1'b1, "R6 line high", 64'(sda_bus), 64'd1);
        bus_stop();

        // R8
        chk(viol == 0, "R8 drive changed while SCL high", 64'(viol), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule